// File: doc/BRIEF.md
# AUX Transaction Register Engine

This block lets a host run one DisplayPort AUX transaction at a time over a byte-wide register bus. The host first programs a 20-bit target address and a 4-bit request code, which share the top address byte. It then programs a length byte, loads any write payload into a transmit FIFO and sets the start bit. The engine holds the request on a plain downstream requester port. The requester takes payload bytes from the transmit FIFO, pushes read bytes into a receive FIFO, and ends the transaction with a reply class and a byte count.

One status byte holds the result: a 3-bit reply class and a 5-bit transferred count. The host drains read data through a single read-data register. Request codes the engine does not support complete at once with the invalid class. If the requester stays silent for longer than a programmable number of cycles, the transaction ends with the timeout class. A magic value written to the configuration register clears the sequencer, the status byte and both FIFOs.

Register offsets: configuration 0x00, address low 0x10, address middle 0x11, address high plus request code 0x12, length 0x13, write data 0x14, read data 0x15, control 0x16, status 0x17, timeout limit 0x18.

Top module: `auxq_engine`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, the read-data register reads 0x00, the timeout register reads 0x40 and dn_req is low.
- R2: The address registers read back as written. dn_addr equals {addr_hi[3:0], addr_mid, addr_lo}, and dn_cmd equals addr_hi[7:4].
- R3: dn_len is 0 when length bit 7 is set. Otherwise it is length[3:0] + 1, giving a range of 1 to 16.
- R4: Bytes written to the write-data register are queued, up to 16 of them, and come out on dn_tx_data in order, one per dn_tx_pop cycle while a transaction runs. A write while the queue holds 16 bytes is dropped. dn_tx_data reads 0 when the queue is empty.
- R5: Writing the control register with bit 0 set starts a transaction when the request code is valid. From the next cycle, control bit 0 and dn_req read 1. Both return to 0 in the cycle after the clock edge that samples dn_rsp high.
- R6: On dn_rsp the status byte becomes {dn_rsp_class, dn_rsp_count}, with the class in bits 7:5 and the count in bits 4:0. The class codes are 1 native NACK, 2 native DEFER, 3 ACK, 4 invalid request, 5 I2C NACK, 6 I2C DEFER and 7 timeout. Status reads 0x00 while a transaction is running.
- R7: Only request codes 0x0 (I2C write), 0x1 (I2C read), 0x8 (native write) and 0x9 (native read) are valid. A start with any other code never raises dn_req and sets status to 0x80.
- R8: If dn_rsp stays low, the transaction ends at the T-th clock edge after the start edge, where T is the timeout register (0 behaves as 1). Status then reads 0xE0.
- R9: Bytes pushed with dn_rx_push during a transaction are read out in order through the read-data register, one byte per read. A read of the empty receive FIFO returns 0x00 and leaves the FIFO unchanged.
- R10: Writing 0xFF to the configuration register ends any running transaction and clears the status and both FIFOs. Any other value written there has no effect.
- R11: Offsets outside the register map read as 0x00, and writes to them change nothing.
- R12: While a transaction is running, writes to the address, length, write-data and timeout registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops read data) |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational |
| dn_req | output | 1 | Transaction pending toward requester |
| dn_cmd | output | 4 | Request code |
| dn_addr | output | 20 | Target address |
| dn_len | output | 5 | Payload byte count 0..16 |
| dn_tx_pop | input | 1 | Requester takes one write byte |
| dn_tx_data | output | 8 | Head of the write-payload FIFO |
| dn_rx_push | input | 1 | Requester delivers one read byte |
| dn_rx_data | input | 8 | Read byte from requester |
| dn_rsp | input | 1 | Reply strobe, ends the transaction |
| dn_rsp_class | input | 3 | Reply class code |
| dn_rsp_count | input | 5 | Bytes actually transferred |

## Verification
The assertions take a one-cycle dn_rsp pulse that arrives only while dn_req is high, and bus_rd and bus_wr never high in the same cycle. The bench acts as the requester itself: it pulses the reply exactly once per accepted request and pops or pushes payload only while dn_req is high. Every register access is a single-cycle strobe driven on the falling edge. Invalid codes and the timeout path are driven so that no reply is ever sent to a request the engine did not raise.

// File: rtl/auxq_pkg.sv
package auxq_pkg;

  localparam logic [7:0] REG_CFG    = 8'h00;
  localparam logic [7:0] REG_ADR_LO = 8'h10;
  localparam logic [7:0] REG_ADR_MD = 8'h11;
  localparam logic [7:0] REG_ADR_HI = 8'h12;
  localparam logic [7:0] REG_LEN    = 8'h13;
  localparam logic [7:0] REG_WDATA  = 8'h14;
  localparam logic [7:0] REG_RDATA  = 8'h15;
  localparam logic [7:0] REG_CTRL   = 8'h16;
  localparam logic [7:0] REG_STAT   = 8'h17;
  localparam logic [7:0] REG_TMO    = 8'h18;

  localparam logic [7:0] CFG_CLEAR  = 8'hFF;

  typedef enum logic [2:0] {
    RC_NONE      = 3'd0,
    RC_NACK      = 3'd1,
    RC_DEFER     = 3'd2,
    RC_ACK       = 3'd3,
    RC_INVALID   = 3'd4,
    RC_I2C_NACK  = 3'd5,
    RC_I2C_DEFER = 3'd6,
    RC_TIMEOUT   = 3'd7
  } reply_cls_e;

  // supported requests: I2C write/read, native write/read
  function automatic logic cmd_ok(input logic [3:0] code);
    return (code == 4'h0) || (code == 4'h1) || (code == 4'h8) || (code == 4'h9);
  endfunction

  // length byte -> payload count (bit 7 = no payload)
  function automatic logic [4:0] len_decode(input logic [7:0] lreg);
    return lreg[7] ? 5'd0 : ({1'b0, lreg[3:0]} + 5'd1);
  endfunction

  function automatic logic [7:0] status_pack(input logic [2:0] cls, input logic [4:0] cnt);
    return {cls, cnt};
  endfunction

endpackage

// File: rtl/auxq_fifo.sv
module auxq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R4: a push into a full queue is dropped
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full && $stable(wr_ptr));

  // R9: popping an empty queue leaves it untouched
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> empty && $stable(rd_ptr));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/auxq_seq.sv
module auxq_seq
  import auxq_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [3:0]       cmd,
  input  logic [TMO_W-1:0] tmo_lim,
  input  logic             rsp,
  input  logic [2:0]       rsp_class,
  input  logic [4:0]       rsp_count,
  output logic             busy,
  output logic [7:0]       status
);
  logic [TMO_W-1:0] wait_cnt;
  logic             tmo_hit;
  logic             accept;
  logic             reject;

  assign tmo_hit = ({1'b0, wait_cnt} + (TMO_W+1)'(1)) >= {1'b0, tmo_lim};
  assign accept  = start && !busy && cmd_ok(cmd);
  assign reject  = start && !busy && !cmd_ok(cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      status   <= '0;
      wait_cnt <= '0;
    end else if (clr) begin
      busy     <= 1'b0;
      status   <= '0;
      wait_cnt <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      status   <= '0;
      wait_cnt <= '0;
    end else if (reject) begin
      status   <= status_pack(RC_INVALID, 5'd0);
    end else if (busy) begin
      if (rsp) begin
        busy   <= 1'b0;
        status <= status_pack(rsp_class, rsp_count);
      end else if (tmo_hit) begin
        busy   <= 1'b0;
        status <= status_pack(RC_TIMEOUT, 5'd0);
      end else begin
        wait_cnt <= wait_cnt + TMO_W'(1);
      end
    end
  end

  p_rsp_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp && !clr |=> !busy && status == $past({rsp_class, rsp_count}));

  p_start_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && cmd_ok(cmd) && !clr |=> busy && status == 8'h00);

  p_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !cmd_ok(cmd) && !clr |=> !busy && status == 8'h80);

  p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp && tmo_hit && !clr |=> !busy && status == 8'hE0);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy && status == 8'h00);

endmodule

// File: rtl/auxq_engine.sv
module auxq_engine
  import auxq_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter int          TMO_W      = 8,
  parameter logic [7:0]  TMO_RESET  = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        dn_req,
  output logic [3:0]  dn_cmd,
  output logic [19:0] dn_addr,
  output logic [4:0]  dn_len,
  input  logic        dn_tx_pop,
  output logic [7:0]  dn_tx_data,
  input  logic        dn_rx_push,
  input  logic [7:0]  dn_rx_data,
  input  logic        dn_rsp,
  input  logic [2:0]  dn_rsp_class,
  input  logic [4:0]  dn_rsp_count
);
  logic [7:0]       adr_lo, adr_md, adr_hi, len_r;
  logic [TMO_W-1:0] tmo_r;
  logic             busy;
  logic [7:0]       status;

  // named events
  logic wr_idle, clr_ev, start_ev, tx_push, tx_pop, rx_push, rx_pop;
  logic [7:0] tx_head, rx_head;
  logic tx_empty, rx_empty;

  assign wr_idle  = bus_wr && !busy;
  assign clr_ev   = bus_wr && (bus_addr == REG_CFG) && (bus_wdata == CFG_CLEAR);
  assign start_ev = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[0];
  assign tx_push  = wr_idle && (bus_addr == REG_WDATA);
  assign tx_pop   = dn_tx_pop && busy;
  assign rx_push  = dn_rx_push && busy;
  assign rx_pop   = bus_rd && (bus_addr == REG_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_lo <= '0;
      adr_md <= '0;
      adr_hi <= '0;
      len_r  <= '0;
      tmo_r  <= TMO_W'(TMO_RESET);
    end else if (wr_idle) begin
      case (bus_addr)
        REG_ADR_LO: adr_lo <= bus_wdata;
        REG_ADR_MD: adr_md <= bus_wdata;
        REG_ADR_HI: adr_hi <= bus_wdata;
        REG_LEN:    len_r  <= bus_wdata;
        REG_TMO:    tmo_r  <= TMO_W'(bus_wdata);
        default: ;
      endcase
    end
  end

  auxq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev),
    .push(tx_push), .pdata(bus_wdata), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty)
  );

  auxq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev),
    .push(rx_push), .pdata(dn_rx_data), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty)
  );

  auxq_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev),
    .start(start_ev), .cmd(adr_hi[7:4]), .tmo_lim(tmo_r),
    .rsp(dn_rsp), .rsp_class(dn_rsp_class), .rsp_count(dn_rsp_count),
    .busy(busy), .status(status)
  );

  assign dn_req     = busy;
  assign dn_cmd     = adr_hi[7:4];
  assign dn_addr    = {adr_hi[3:0], adr_md, adr_lo};
  assign dn_len     = len_decode(len_r);
  assign dn_tx_data = tx_empty ? 8'h00 : tx_head;

  always_comb begin
    case (bus_addr)
      REG_ADR_LO: bus_rdata = adr_lo;
      REG_ADR_MD: bus_rdata = adr_md;
      REG_ADR_HI: bus_rdata = adr_hi;
      REG_LEN:    bus_rdata = len_r;
      REG_RDATA:  bus_rdata = rx_empty ? 8'h00 : rx_head;
      REG_CTRL:   bus_rdata = {7'b0, busy};
      REG_STAT:   bus_rdata = status;
      REG_TMO:    bus_rdata = 8'(tmo_r);
      default:    bus_rdata = 8'h00;
    endcase
  end

  // R12: setup registers frozen while a transaction runs
  p_busy_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr |=> $stable(adr_lo) && $stable(adr_md) && $stable(adr_hi)
                       && $stable(len_r) && $stable(tmo_r));

  // R1/R5: the request line follows the sequencer and drops after clear
  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !dn_req);

endmodule

// File: tb/auxq_engine_test.sv
module auxq_engine_test;
  import auxq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        dn_req;
  logic [3:0]  dn_cmd;
  logic [19:0] dn_addr;
  logic [4:0]  dn_len;
  logic        dn_tx_pop = 1'b0;
  logic [7:0]  dn_tx_data;
  logic        dn_rx_push = 1'b0;
  logic [7:0]  dn_rx_data = '0;
  logic        dn_rsp = 1'b0;
  logic [2:0]  dn_rsp_class = '0;
  logic [4:0]  dn_rsp_count = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  auxq_engine uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dn_req(dn_req), .dn_cmd(dn_cmd), .dn_addr(dn_addr), .dn_len(dn_len),
    .dn_tx_pop(dn_tx_pop), .dn_tx_data(dn_tx_data),
    .dn_rx_push(dn_rx_push), .dn_rx_data(dn_rx_data),
    .dn_rsp(dn_rsp), .dn_rsp_class(dn_rsp_class), .dn_rsp_count(dn_rsp_count)
  );

  // table: cmd, length byte, reply class, reply count, expected status, valid
  localparam logic [31:0] VEC [7] = '{
    {4'h9, 8'h0F, 3'd3, 5'd16, 8'h70, 3'b0, 1'b1},
    {4'h8, 8'h80, 3'd1, 5'd0,  8'h20, 3'b0, 1'b1},
    {4'h1, 8'h03, 3'd6, 5'd2,  8'hC2, 3'b0, 1'b1},
    {4'h0, 8'h00, 3'd5, 5'd0,  8'hA0, 3'b0, 1'b1},
    {4'h2, 8'h05, 3'd3, 5'd1,  8'h80, 3'b0, 1'b0},
    {4'hF, 8'h01, 3'd3, 5'd1,  8'h80, 3'b0, 1'b0},
    {4'h9, 8'h01, 3'd2, 5'd1,  8'h41, 3'b0, 1'b1}
  };

  function automatic int exp_len(input logic [7:0] lb);
    if (lb >= 8'h80) return 0;
    return int'(lb % 16) + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic reply(input logic [2:0] c, input logic [4:0] n);
    @(negedge clk);
    dn_rsp = 1'b1; dn_rsp_class = c; dn_rsp_count = n;
    @(posedge clk); #1;
    dn_rsp = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] d);
    @(negedge clk);
    d = dn_tx_data; dn_tx_pop = 1'b1;
    @(posedge clk); #1;
    dn_tx_pop = 1'b0;
  endtask

  task automatic rx_give(input logic [7:0] d);
    @(negedge clk);
    dn_rx_push = 1'b1; dn_rx_data = d;
    @(posedge clk); #1;
    dn_rx_push = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(REG_CTRL, v);  chk("R1 ctrl", v, 8'h00);
    rd(REG_STAT, v);  chk("R1 status", v, 8'h00);
    rd(REG_RDATA, v); chk("R1 rdata", v, 8'h00);
    rd(REG_TMO, v);   chk("R1 tmo", v, 8'h40);
    chk("R1 dn_req", dn_req, 0);

    // R2 address packing and readback
    wr(REG_ADR_LO, 8'h34); wr(REG_ADR_MD, 8'h12); wr(REG_ADR_HI, 8'h9A);
    rd(REG_ADR_HI, v); chk("R2 adr_hi readback", v, 8'h9A);
    rd(REG_ADR_MD, v); chk("R2 adr_md readback", v, 8'h12);
    chk("R2 dn_addr", dn_addr, 20'hA1234);
    chk("R2 dn_cmd", dn_cmd, 4'h9);

    // table walk: R3 length, R5 handshake, R6 status, R7 invalid codes
    for (int i = 0; i < 7; i++) begin
      logic [31:0] e;
      e = VEC[i];
      wr(REG_ADR_HI, {e[31:28], 4'h5});
      wr(REG_LEN, e[27:20]);
      chk("R3 dn_len", dn_len, 32'(exp_len(e[27:20])));
      wr(REG_CTRL, 8'h01);
      if (e[0]) begin
        chk("R5 dn_req high", dn_req, 1);
        rd(REG_CTRL, v); chk("R5 ctrl busy", v, 8'h01);
        rd(REG_STAT, v); chk("R6 status during run", v, 8'h00);
        reply(e[19:17], e[16:12]);
        chk("R5 dn_req low", dn_req, 0);
      end else begin
        chk("R7 no request", dn_req, 0);
      end
      rd(REG_STAT, v);
      chk(e[0] ? "R6 status" : "R7 invalid status", v, 32'(e[11:4]));
    end

    // R8 timeout after T edges
    wr(REG_TMO, 8'd5);
    wr(REG_ADR_HI, 8'h80);
    wr(REG_CTRL, 8'h01);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk("R8 still busy", dn_req, 1);
    end
    @(posedge clk); #1;
    chk("R8 ended at T", dn_req, 0);
    rd(REG_STAT, v); chk("R8 timeout status", v, 8'hE0);
    wr(REG_TMO, 8'h40);

    // R4 payload queue order and overflow drop
    for (int k = 0; k < 17; k++) wr(REG_WDATA, (k == 16) ? 8'hEE : 8'(8'hA0 + k));
    wr(REG_LEN, 8'h0F);
    wr(REG_CTRL, 8'h01);
    for (int k = 0; k < 16; k++) begin
      tx_take(v);
      chk("R4 payload order", v, 8'(8'hA0 + k));
    end
    chk("R4 extra byte dropped", dn_tx_data, 8'h00);
    reply(3'd3, 5'd16);

    // R9 read data path
    wr(REG_ADR_HI, 8'h90);
    wr(REG_CTRL, 8'h01);
    rx_give(8'h11); rx_give(8'h22); rx_give(8'h33);
    reply(3'd3, 5'd3);
    rd(REG_RDATA, v); chk("R9 rdata 0", v, 8'h11);
    rd(REG_RDATA, v); chk("R9 rdata 1", v, 8'h22);
    rd(REG_RDATA, v); chk("R9 rdata 2", v, 8'h33);
    rd(REG_RDATA, v); chk("R9 empty read", v, 8'h00);
    wr(REG_CTRL, 8'h01);
    rx_give(8'h44);
    reply(3'd3, 5'd1);
    rd(REG_RDATA, v); chk("R9 after empty read", v, 8'h44);

    // R12 writes ignored while busy
    wr(REG_ADR_LO, 8'h34);
    wr(REG_CTRL, 8'h01);
    wr(REG_ADR_LO, 8'hFF); wr(REG_LEN, 8'h07); wr(REG_WDATA, 8'h5A); wr(REG_TMO, 8'h02);
    rd(REG_ADR_LO, v); chk("R12 adr ignored", v, 8'h34);
    rd(REG_LEN, v);    chk("R12 len ignored", v, 8'h0F);
    rd(REG_TMO, v);    chk("R12 tmo ignored", v, 8'h40);
    chk("R12 wdata ignored", dn_tx_data, 8'h00);
    reply(3'd3, 5'd0);

    // R10 configuration clear
    wr(REG_WDATA, 8'h61); wr(REG_WDATA, 8'h62);
    wr(REG_CFG, 8'h55);
    chk("R10 other value no effect", dn_tx_data, 8'h61);
    wr(REG_CFG, 8'hFF);
    chk("R10 tx cleared", dn_tx_data, 8'h00);
    wr(REG_CTRL, 8'h01);
    rx_give(8'h77);
    wr(REG_CFG, 8'hFF);
    chk("R10 busy cleared", dn_req, 0);
    rd(REG_STAT, v);  chk("R10 status cleared", v, 8'h00);
    rd(REG_RDATA, v); chk("R10 rx cleared", v, 8'h00);

    // R11 unmapped offsets
    wr(8'h40, 8'h3C);
    rd(8'h40, v);    chk("R11 unmapped read", v, 8'h00);
    rd(REG_CFG, v);  chk("R11 cfg reads zero", v, 8'h00);
    rd(REG_ADR_LO, v); chk("R11 no side effect", v, 8'h34);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule